// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block links a single-beat request port to an external asynchronous static RAM of 32,768 bytes. A requester presents a 15-bit word address, a write flag and a data byte together with a valid strobe. The request is taken on a clock edge where both valid and ready are high. The controller then runs a fixed sequence of bus phases on the memory's active-low chip, output and write enables. When the access is over it pulses `done_o`; for a read, `rdata_o` carries the byte in that same cycle.

Each memory timing interval becomes a wait-state count: the required time in picoseconds is divided by the clock period and rounded up, with a minimum of one cycle. Writes are strobed by write enable while output enable stays low. The data driver therefore holds off for a turnaround window after write enable falls, so that the memory's outputs can turn off first. The bidirectional byte bus is split into an output value, an output enable and an input value, and the pad is left to the chip level.

The state machine has six states:
- IDLE: request accepted → ADDR.
- ADDR: address settles, all strobes high → READ or WR_TURN.
- READ: access window; at its end the byte is captured → IDLE.
- WR_TURN: turnaround expired → WR_DATA.
- WR_DATA: setup expired → WR_REL.
- WR_REL: one cycle → IDLE.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, all three strobes are high, the data driver is off, `req_ready_o` is 1 and `done_o` is 0.
- R2: Strobe encoding (all active low): idle and address phases drive chip, output and write enable all high; a read drives chip and output enable low with write enable high; a write drives chip, write and output enable all low.
- R3: `sram_addr_o` changes value only in a cycle in which chip enable and write enable are both high, and both were also high in the cycle before.
- R4: After acceptance, a read spends one cycle with all strobes high and then exactly RD_CYC cycles with chip and output enable low. The input byte is sampled on the edge that closes that window. In the next cycle `done_o` is 1 and `rdata_o` holds the sampled byte.
- R5: After its address cycle, a write holds write enable low for TURN_CYC + SETUP_CYC cycles. During the first TURN_CYC cycles the data driver is off. During the last SETUP_CYC cycles it is on, with `sram_dq_o` equal to the accepted write byte.
- R6: Chip enable and write enable rise together at the end of a write. The driver stays on with the same byte for that one cycle and is off in the next cycle, which is also the cycle in which `done_o` is 1.
- R7: The data driver is never on while the memory has its outputs enabled (chip enable low, output enable low, write enable high).
- R8: `req_ready_o` is 1 only in the idle state. A request held valid while the controller is busy is neither accepted nor able to disturb the bus sequence; it is taken on the first edge at which ready is 1.
- R9: RD_CYC = max(1, ceil(ACCESS_PS / CLK_PERIOD_PS)) and TURN_CYC = max(1, ceil(TURNOFF_PS / CLK_PERIOD_PS)). SETUP_CYC = max(1, ceil((DATA_SETUP_PS + 1) / CLK_PERIOD_PS)), which keeps the write strobe strictly longer than turn-off plus setup.
- R10: `done_o` is a single-cycle pulse, one per accepted request.
- R11: A byte written to any address, including 0x0000 and 0x7FFF, is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 15 | Word address |
| req_wdata_i | input | 8 | Write byte |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | Access finished (one cycle) |
| rdata_o | output | 8 | Read byte, valid with `done_o` after a read |
| sram_ce_n_o | output | 1 | Memory chip enable, active low |
| sram_oe_n_o | output | 1 | Memory output enable, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_addr_o | output | 15 | Memory address bus |
| sram_dq_o | output | 8 | Byte driven towards the memory |
| sram_dq_oe_o | output | 1 | Driver enable for `sram_dq_o` |
| sram_dq_i | input | 8 | Byte read from the memory bus |

## Verification
The bound checker watches the rules that must hold in every cycle. It checks address stability against the strobes, that the driver is never on while the memory's outputs are enabled, that the driver is off on the edge where write enable falls and is released one cycle after write enable rises, that output enable stays low under a write strobe, that the strobes are quiet while ready is high, and that done is a one-cycle pulse. Exact phase lengths, the byte that appears on the bus, the value returned by a read, and the way a request held during a busy period waits for idle need the bench's per-cycle reference model. That model runs with non-trivial wait counts and is paired with a memory model that stores written bytes and flags bus contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_READ    = 3'd2,
        ST_WR_TURN = 3'd3,
        ST_WR_DATA = 3'd4,
        ST_WR_REL  = 3'd5
    } sram_state_e;

    // Ceiling of a time over the clock period, never below one cycle (R9)
    function automatic int wait_cycles(input int time_ps, input int period_ps);
        int c;
        c = (time_ps + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Loading N makes expire_o high in the N-th cycle after the load edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int RD_CYC    = 1,
    parameter int TURN_CYC  = 1,
    parameter int SETUP_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             tmr_expire_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             accept_o,
    output logic             capture_o,
    output logic             ready_o,
    output logic             done_o,
    output logic             ce_n_o,
    output logic             oe_n_o,
    output logic             we_n_o,
    output logic             drive_o
);
    sram_state_e state_q, state_d;
    logic        wr_q;
    logic        done_q;

    // Next state and timer control
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        accept_o   = 1'b0;
        capture_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    accept_o = 1'b1;
                    state_d  = ST_ADDR;
                end
            end
            ST_ADDR: begin
                tmr_load_o = 1'b1;
                if (wr_q) begin
                    tmr_val_o = CNT_W'(TURN_CYC);
                    state_d   = ST_WR_TURN;
                end else begin
                    tmr_val_o = CNT_W'(RD_CYC);
                    state_d   = ST_READ;
                end
            end
            ST_READ: begin
                if (tmr_expire_i) begin
                    capture_o = 1'b1;
                    state_d   = ST_IDLE;
                end
            end
            ST_WR_TURN: begin
                if (tmr_expire_i) begin
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CNT_W'(SETUP_CYC);
                    state_d    = ST_WR_DATA;
                end
            end
            ST_WR_DATA: begin
                if (tmr_expire_i) begin
                    state_d = ST_WR_REL;
                end
            end
            ST_WR_REL: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                wr_q <= req_write_i;
            end
            done_q <= capture_o || (state_q == ST_WR_REL);
        end
    end

    // Moore outputs decoded from the state register
    always_comb begin
        ce_n_o  = 1'b1;
        oe_n_o  = 1'b1;
        we_n_o  = 1'b1;
        drive_o = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o = 1'b1;
            end
            ST_ADDR: begin
                ready_o = 1'b0;
            end
            ST_READ: begin
                ce_n_o = 1'b0;
                oe_n_o = 1'b0;
            end
            ST_WR_TURN: begin
                ce_n_o = 1'b0;
                oe_n_o = 1'b0;
                we_n_o = 1'b0;
            end
            ST_WR_DATA: begin
                ce_n_o  = 1'b0;
                oe_n_o  = 1'b0;
                we_n_o  = 1'b0;
                drive_o = 1'b1;
            end
            ST_WR_REL: begin
                drive_o = 1'b1;
            end
            default: begin
                ready_o = 1'b0;
            end
        endcase
    end

    assign done_o = done_q;

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] dq_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Address and write byte only move on acceptance, i.e. from idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept_i) begin
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
            end
            if (capture_i) begin
                rdata_q <= dq_i;
            end
        end
    end

    assign addr_o  = addr_q;
    assign dq_o    = wdata_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_PS = 20000,
    parameter int ACCESS_PS     = 15000,
    parameter int TURNOFF_PS    = 8000,
    parameter int DATA_SETUP_PS = 8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              sram_ce_n_o,
    output logic              sram_oe_n_o,
    output logic              sram_we_n_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe_o,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int RD_CYC    = wait_cycles(ACCESS_PS, CLK_PERIOD_PS);
    localparam int TURN_CYC  = wait_cycles(TURNOFF_PS, CLK_PERIOD_PS);
    localparam int SETUP_CYC = wait_cycles(DATA_SETUP_PS + 1, CLK_PERIOD_PS);
    localparam int MAX_CYC   = (RD_CYC > TURN_CYC)
                               ? ((RD_CYC > SETUP_CYC) ? RD_CYC : SETUP_CYC)
                               : ((TURN_CYC > SETUP_CYC) ? TURN_CYC : SETUP_CYC);
    localparam int CNT_W     = $clog2(MAX_CYC + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic             accept;
    logic             capture;

    sram_wait_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expire_o   (tmr_expire)
    );

    sram_ctrl_fsm #(
        .CNT_W     (CNT_W),
        .RD_CYC    (RD_CYC),
        .TURN_CYC  (TURN_CYC),
        .SETUP_CYC (SETUP_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid_i),
        .req_write_i  (req_write_i),
        .tmr_expire_i (tmr_expire),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .accept_o     (accept),
        .capture_o    (capture),
        .ready_o      (req_ready_o),
        .done_o       (done_o),
        .ce_n_o       (sram_ce_n_o),
        .oe_n_o       (sram_oe_n_o),
        .we_n_o       (sram_we_n_o),
        .drive_o      (sram_dq_oe_o)
    );

    sram_io_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_io (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .capture_i   (capture),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .dq_i        (sram_dq_i),
        .addr_o      (sram_addr_o),
        .dq_o        (sram_dq_o),
        .rdata_o     (rdata_o)
    );

endmodule

// File: rtl/async_sram_ctrl_chk.sv
module async_sram_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready_o,
    input logic              done_o,
    input logic              sram_ce_n_o,
    input logic              sram_oe_n_o,
    input logic              sram_we_n_o,
    input logic [ADDR_W-1:0] sram_addr_o,
    input logic              sram_dq_oe_o
);
    p_addr_moves_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_addr_o != $past(sram_addr_o)) |->
            (sram_ce_n_o && sram_we_n_o && $past(sram_ce_n_o) && $past(sram_we_n_o)));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe_o |-> !(!sram_ce_n_o && !sram_oe_n_o && sram_we_n_o));

    p_drive_off_at_we_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_we_n_o) |-> !sram_dq_oe_o);

    p_drive_only_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe_o |-> (!sram_we_n_o || $rose(sram_we_n_o)));

    p_release_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n_o) |=> !sram_dq_oe_o);

    p_ce_with_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n_o) |-> $rose(sram_ce_n_o));

    p_write_encoding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n_o |-> (!sram_ce_n_o && !sram_oe_n_o));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (sram_ce_n_o && sram_oe_n_o && sram_we_n_o && !sram_dq_oe_o));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

bind async_sram_ctrl async_sram_ctrl_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready_o  (req_ready_o),
    .done_o       (done_o),
    .sram_ce_n_o  (sram_ce_n_o),
    .sram_oe_n_o  (sram_oe_n_o),
    .sram_we_n_o  (sram_we_n_o),
    .sram_addr_o  (sram_addr_o),
    .sram_dq_oe_o (sram_dq_oe_o)
);

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;

    localparam int PER_PS   = 20000;
    localparam int ACC_PS   = 45000;
    localparam int TOFF_PS  = 30000;
    localparam int SETUP_PS = 25000;

    function automatic int cyc_of(input int t);
        int c;
        c = t / PER_PS;
        if (c * PER_PS < t) c = c + 1;
        if (c < 1) c = 1;
        return c;
    endfunction

    localparam int RD_C = cyc_of(ACC_PS);         // R9: 3
    localparam int TN_C = cyc_of(TOFF_PS);        // R9: 2
    localparam int SU_C = cyc_of(SETUP_PS + 1);   // R9: 2

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic        ce_n, oe_n, we_n, dq_oe;
    logic [14:0] sram_addr;
    logic [7:0]  dq_out, bus, mem_val;
    logic        mem_drv;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    async_sram_ctrl #(
        .CLK_PERIOD_PS (PER_PS),
        .ACCESS_PS     (ACC_PS),
        .TURNOFF_PS    (TOFF_PS),
        .DATA_SETUP_PS (SETUP_PS)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_wdata_i  (req_wdata),
        .req_ready_o  (req_ready),
        .done_o       (done),
        .rdata_o      (rdata),
        .sram_ce_n_o  (ce_n),
        .sram_oe_n_o  (oe_n),
        .sram_we_n_o  (we_n),
        .sram_addr_o  (sram_addr),
        .sram_dq_o    (dq_out),
        .sram_dq_oe_o (dq_oe),
        .sram_dq_i    (bus)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem_arr [int];
    logic [7:0] shadow  [int];
    bit         strobe_was;
    logic [14:0] strobe_addr;
    logic [7:0]  strobe_bus;

    assign mem_drv = !ce_n && !oe_n && we_n;
    assign bus = dq_oe ? dq_out : (mem_drv ? mem_val : 8'h00);

    always @(negedge clk) begin
        if (strobe_was && !(!ce_n && !we_n)) begin
            mem_arr[int'(strobe_addr)] = strobe_bus;
        end
        strobe_was  = !ce_n && !we_n;
        strobe_addr = sram_addr;
        strobe_bus  = bus;
        mem_val = mem_arr.exists(int'(sram_addr)) ? mem_arr[int'(sram_addr)] : 8'h00;
        if (rst_n) begin
            check(!(dq_oe && mem_drv), "R7 bus contention", 1, 0);
        end
    end

    // ---------------- cycle reference model ----------------
    bit          busy = 1'b0, op_w = 1'b0, pend_done = 1'b0, pend_w = 1'b0;
    logic [14:0] op_a = '0, prev_addr = '0;
    logic [7:0]  op_d = '0, pend_rd = '0;
    int          p = 0, blen = 0;
    bit          prev_hi = 1'b1, started = 1'b0;

    always @(negedge clk) begin
        bit e_ce, e_oe, e_we, e_drv, e_rdy, e_done;
        if (!rst_n) begin
            busy = 0; pend_done = 0; started = 0;
        end else begin
            e_ce = 1; e_oe = 1; e_we = 1; e_drv = 0; e_rdy = 0; e_done = 0;
            if (!busy) begin
                e_rdy = 1; e_done = pend_done;
            end else if (!op_w) begin
                if (p >= 1) begin e_ce = 0; e_oe = 0; end
            end else begin
                if (p >= 1 && p <= TN_C + SU_C) begin e_ce = 0; e_oe = 0; e_we = 0; end
                if (p > TN_C && p <= TN_C + SU_C + 1) e_drv = 1;
            end
            check(ce_n == e_ce, "R2 chip enable", ce_n, e_ce);
            check(oe_n == e_oe, "R4 output enable", oe_n, e_oe);
            check(we_n == e_we, "R5 write enable", we_n, e_we);
            check(dq_oe == e_drv, "R6 data driver", dq_oe, e_drv);
            check(req_ready == e_rdy, "R8 ready", req_ready, e_rdy);
            check(done == e_done, "R10 done pulse", done, e_done);
            if (busy) check(sram_addr == op_a, "R3 address", sram_addr, op_a);
            if (e_drv) check(dq_out == op_d, "R5 write byte", dq_out, op_d);
            if (e_done && !pend_w) check(rdata == pend_rd, "R11 read data", rdata, pend_rd);
            if (started && sram_addr != prev_addr) begin
                check(ce_n && we_n && prev_hi, "R3 address moved under strobe", 0, 1);
            end
            prev_addr = sram_addr;
            prev_hi   = ce_n && we_n;
            started   = 1;
            if (busy) begin
                p++;
                if (p == blen) begin
                    busy = 0; pend_done = 1; pend_w = op_w;
                    if (op_w) shadow[int'(op_a)] = op_d;
                    else pend_rd = shadow.exists(int'(op_a)) ? shadow[int'(op_a)] : 8'h00;
                end
            end else begin
                pend_done = 0;
                if (req_valid) begin
                    busy = 1; p = 0; op_w = req_write; op_a = req_addr; op_d = req_wdata;
                    blen = op_w ? (2 + TN_C + SU_C) : (1 + RD_C);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input logic [14:0] a, input logic [7:0] d);
        bit r;
        @(posedge clk); #5;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        r = 0;
        while (!r) begin
            @(negedge clk);
            r = req_ready;
        end
        @(posedge clk); #5;
        req_valid = 0; req_write = 0; req_addr = ~a; req_wdata = ~d;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check(ce_n && oe_n && we_n, "R1 strobes in reset", {ce_n, oe_n, we_n}, 7);
        check(!dq_oe, "R1 driver in reset", dq_oe, 0);
        check(req_ready && !done, "R1 ready/done in reset", {req_ready, done}, 2);
        @(posedge clk); #5 rst_n = 1;
        @(negedge clk);
        check(req_ready && !done && ce_n, "R1 after reset", {req_ready, done, ce_n}, 5);

        issue(1, 15'h0000, 8'hA5);       // R11 lowest address
        issue(1, 15'h7FFF, 8'h3C);       // R11 highest address
        issue(0, 15'h0000, 8'h00);
        issue(0, 15'h7FFF, 8'h00);
        issue(0, 15'h1234, 8'h00);       // never written
        issue(1, 15'h1234, 8'h81);
        issue(0, 15'h1234, 8'h00);       // read right after write, same address
        issue(1, 15'h1234, 8'h7E);       // write right after read (R7 turnaround)
        issue(0, 15'h1234, 8'h00);
        lfsr = 16'hACE1;
        for (int i = 0; i < 24; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(1, lfsr[14:0], lfsr[7:0] ^ 8'h5A);
            issue(0, lfsr[14:0], 8'h00);
        end
        repeat (8) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        finish_run();
    end

endmodule